// File: doc/BRIEF.md
# Multi-Phase Serial Audio Transmitter

This block turns parallel audio words into a serial bit stream. The bit clock and the frame sync come from outside and arrive as plain levels sampled by the fast system clock. A frame holds one or two phases. Each phase has its own word length and its own number of words. A frame begins on a frame-sync start event. The first data bit appears either at that same bit-clock drive edge or one bit later. Words are sent most significant bit first, and the line is driven low whenever no frame is active.

Words come in through one holding register with a ready/valid handshake. The ready signal also serves as the transmit request: it is high whenever the holding register is empty and the block is enabled. A word is taken from the holding register when its first bit is due. If no word is waiting at that point, the previous word is sent again and a sticky underrun flag is set.

A hold control keeps the transmitter idle and clears all of its shifting state. All configuration inputs are expected to change only while hold is asserted. The bit clock must be slower than a quarter of the system clock.

Top module: `audio_ser_tx`

## Requirements
- R1: The 3-bit word length code selects the number of bits per word: 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6 or 7 give 32. A word of N bits is sent as in_data[N-1] first, down to in_data[0].
- R2: With cfg_dual low, a frame has cfg_cnt0+1 words, each of the phase-one length.
- R3: With cfg_dual high, the phase-one words are followed by cfg_cnt1+1 words of the phase-two length, and the frame ends after them.
- R4: With cfg_delay low, the MSB of the first word is driven at the same drive edge at which the frame-sync start event is seen.
- R5: With cfg_delay high, the line is held low for one bit after the start event and the MSB follows at the next drive edge. A start event seen at the drive edge that sends a frame's final bit is honoured, so back-to-back frames need no spare bit.
- R6: With cfg_fs_ignore high, start events during a frame are ignored. With it low, such an event restarts the frame from its first word, and the data delay applies.
- R7: While tx_hold is high, the line is low one clock later, in_ready is low, the holding register is emptied, the underrun flag is cleared and frame state is reset.
- R8: With cfg_clk_pol high, tx_sd changes only after a falling bit-clock edge; with it low, only after a rising edge. The output follows one system clock after the edge is first sampled.
- R9: With cfg_fs_pol low, fsync is active high; with it high, fsync is active low. A start event is the inactive-to-active change of fsync, judged between consecutive drive edges.
- R10: tx_sd is 0 at every drive edge where no frame bit is due.
- R11: in_ready is high exactly when the holding register is empty and tx_hold is low. A word is captured when in_valid and in_ready are both high, and the register empties when the word is copied into the shifter.
- R12: If the holding register is empty when a new word is due, the previously sent word is sent again (its low bits, at the current length). The underrun output is then set and stays set until tx_hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_hold | input | 1 | Holds the transmitter idle and clears its state |
| cfg_dual | input | 1 | 1 selects a two-phase frame |
| cfg_len0 | input | 3 | Phase-one word length code |
| cfg_cnt0 | input | CNT_W | Phase-one word count minus one |
| cfg_len1 | input | 3 | Phase-two word length code |
| cfg_cnt1 | input | CNT_W | Phase-two word count minus one |
| cfg_delay | input | 1 | Data delay after frame sync, 0 or 1 bit |
| cfg_fs_ignore | input | 1 | 1 ignores start events within a frame |
| cfg_clk_pol | input | 1 | 1 drives on falling bit-clock edges, 0 on rising |
| cfg_fs_pol | input | 1 | 0 active-high frame sync, 1 active-low |
| bclk | input | 1 | External bit clock, synchronous to clk |
| fsync | input | 1 | External frame sync, synchronous to clk |
| in_data | input | 32 | Word to transmit, right-justified |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Holding register empty; acts as transmit request |
| tx_sd | output | 1 | Serial data out |
| underrun | output | 1 | Sticky: a word was repeated for lack of data |

## Verification
The embedded assertions check these properties on every cycle:
- the line is low one clock after hold;
- tx_sd never moves except after a drive edge;
- a waiting word is never overwritten or lost before it is copied;
- the underrun flag stays set;
- the bit index stays inside the current word;
- an ignored start event leaves a running frame running.

The actual bit order, the phase sequencing, the delay placement, back-to-back framing, the restart-versus-ignore outcome and the repeated word on underrun can only be shown by the bench's scenarios. There, a queue-based model predicts tx_sd, in_ready and underrun cycle by cycle for each configuration.

// File: rtl/astx_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the serial audio transmitter: word and bit-index
// widths, the sequencer state type and the word length decoder.
package astx_pkg;

    localparam int WORD_W = 32;
    localparam int BIT_W  = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;

    // Map a 3-bit length code onto a bit count (codes above 4 mean 32 bits).
    function automatic logic [5:0] code_to_bits(input logic [2:0] code);
        logic [5:0] n;
        case (code)
            3'd0:    n = 6'd8;
            3'd1:    n = 6'd12;
            3'd2:    n = 6'd16;
            3'd3:    n = 6'd20;
            3'd4:    n = 6'd24;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/astx_edge.sv
`timescale 1ns/1ps
// Edge and frame-start detector.
// Detects the bit-clock drive edge chosen by the clock polarity. It also
// reports a frame-start event, which is an inactive-to-active change of
// frame sync between two drive edges.
// Assumes bclk and fsync are synchronous to clk and change no more often
// than every two clk cycles.
module astx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic clk_pol,
    input  logic fs_pol,
    input  logic bclk,
    input  logic fsync,
    output logic drive_ev,
    output logic fs_start
);

    logic bclk_q;
    logic fs_prev;
    logic fs_act;

    assign fs_act   = fsync ^ fs_pol;
    assign drive_ev = (bclk ^ bclk_q) & (bclk ^ clk_pol);
    assign fs_start = drive_ev & fs_act & ~fs_prev;

    // Remember the previous bit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk;
    end

    // Track the frame-sync level seen at the last drive edge.
    // It starts as active so that a pulse already in progress is not a start.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) fs_prev <= 1'b1;
        else if (drive_ev)  fs_prev <= fs_act;
    end

    // R9
    start_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_start |=> !fs_start);

endmodule

// File: rtl/astx_hold.sv
`timescale 1ns/1ps
// Transmit holding register.
// Holds one word with a ready/valid handshake on the write side. It is
// emptied when the sequencer copies the word into the shifter.
// Assumes pop is only raised while the register is full.
module astx_hold
    import astx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              pop,
    output logic              full,
    output logic [WORD_W-1:0] data
);

    assign in_ready = ~full & ~hold;

    // Fill on handshake, empty on pop, clear under hold.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (pop) full <= 1'b0;
            if (in_valid && in_ready) begin
                full <= 1'b1;
                data <= in_data;
            end
        end
    end

    // R11
    keep_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !hold) |=> (full && $stable(data)));

    // R11
    pop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !hold) |=> !full);

endmodule

// File: rtl/astx_seq.sv
`timescale 1ns/1ps
// Frame sequencer and shifter.
// On each drive edge it decides what goes on the line. The choices are:
// start a frame, wait out the delay bit, shift the next bit, move to the
// next word or phase, or end the frame. New words are taken from the
// holding register when they are needed.
// Assumes configuration changes only while hold is high.
module astx_seq
    import astx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              drive_ev,
    input  logic              fs_start,
    input  logic              cfg_dual,
    input  logic [2:0]        cfg_len0,
    input  logic [CNT_W-1:0]  cfg_cnt0,
    input  logic [2:0]        cfg_len1,
    input  logic [CNT_W-1:0]  cfg_cnt1,
    input  logic              cfg_delay,
    input  logic              cfg_fs_ignore,
    input  logic              buf_full,
    input  logic [WORD_W-1:0] buf_data,
    output logic              pop,
    output logic              tx_sd,
    output logic              underrun
);

    tx_state_e         state, n_state;
    logic              ph, n_ph;
    logic [CNT_W-1:0]  wcnt, n_wcnt;
    logic [BIT_W-1:0]  bidx, n_bidx;
    logic [WORD_W-1:0] sh_word, n_word;
    logic              n_sd;
    logic              do_load;
    logic [5:0]        ld_len;

    logic [5:0]        len0_b, len1_b, cur_len;
    logic [CNT_W-1:0]  cur_cnt;
    logic              last_w, last_ph, fin, nxt, accept;

    assign len0_b  = code_to_bits(cfg_len0);
    assign len1_b  = code_to_bits(cfg_len1);
    assign cur_len = ph ? len1_b : len0_b;
    assign cur_cnt = ph ? cfg_cnt1 : cfg_cnt0;
    assign last_w  = (wcnt == cur_cnt);
    assign last_ph = ph | ~cfg_dual;
    assign fin     = (state == ST_SHIFT) && (bidx == '0) && last_w && last_ph;
    assign nxt     = (state == ST_SHIFT) && (bidx == 5'd1) && last_w && last_ph;
    assign accept  = fs_start && ((state == ST_IDLE) || fin
                     || (cfg_delay && nxt) || !cfg_fs_ignore);
    assign pop     = do_load & buf_full;

    // Choose the next line bit and frame position for this drive edge.
    always_comb begin
        n_state = state;
        n_ph    = ph;
        n_wcnt  = wcnt;
        n_bidx  = bidx;
        n_word  = sh_word;
        n_sd    = tx_sd;
        do_load = 1'b0;
        ld_len  = len0_b;
        if (drive_ev) begin
            if (accept && !cfg_delay) begin
                n_ph    = 1'b0;
                n_wcnt  = '0;
                do_load = 1'b1;
                n_state = ST_SHIFT;
            end else if (accept && nxt) begin
                n_bidx  = '0;
                n_sd    = sh_word[0];
                n_state = ST_WAIT;
            end else if (accept) begin
                n_sd    = 1'b0;
                n_state = ST_WAIT;
            end else begin
                case (state)
                    ST_WAIT: begin
                        n_ph    = 1'b0;
                        n_wcnt  = '0;
                        do_load = 1'b1;
                        n_state = ST_SHIFT;
                    end
                    ST_SHIFT: begin
                        if (fin) begin
                            n_sd    = 1'b0;
                            n_state = ST_IDLE;
                        end else if (bidx != '0) begin
                            n_bidx = bidx - 5'd1;
                            n_sd   = sh_word[bidx - 5'd1];
                        end else if (!last_w) begin
                            n_wcnt  = wcnt + 1'b1;
                            do_load = 1'b1;
                            ld_len  = cur_len;
                        end else begin
                            n_ph    = 1'b1;
                            n_wcnt  = '0;
                            do_load = 1'b1;
                            ld_len  = len1_b;
                        end
                    end
                    default: ;
                endcase
            end
        end
        if (do_load) begin
            n_word = buf_full ? buf_data : sh_word;
            n_bidx = 5'(ld_len - 6'd1);
            n_sd   = n_word[n_bidx];
        end
    end

    // Register the frame position, the shifter and the line.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            state    <= ST_IDLE;
            ph       <= 1'b0;
            wcnt     <= '0;
            bidx     <= '0;
            sh_word  <= '0;
            tx_sd    <= 1'b0;
            underrun <= 1'b0;
        end else begin
            state    <= n_state;
            ph       <= n_ph;
            wcnt     <= n_wcnt;
            bidx     <= n_bidx;
            sh_word  <= n_word;
            tx_sd    <= n_sd;
            underrun <= underrun | (do_load & ~buf_full);
        end
    end

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (tx_sd == 1'b0));

    // R8
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_ev && !hold) |=> $stable(tx_sd));

    // R12
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !hold) |=> underrun);

    // R1
    bit_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !hold) |-> ({1'b0, bidx} < cur_len));

    // R6
    ignore_keeps_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && fs_start && cfg_fs_ignore && state == ST_SHIFT && !fin
         && !(cfg_delay && nxt)) |=> (state == ST_SHIFT));

endmodule

// File: rtl/audio_ser_tx.sv
`timescale 1ns/1ps
// Multi-phase serial audio transmitter, top level.
// Connects the edge detector, the holding register and the sequencer.
// Assumes bclk and fsync are synchronous to clk, the bit clock runs
// below a quarter of clk, and the configuration is stable outside hold.
module audio_ser_tx
    import astx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_hold,
    input  logic              cfg_dual,
    input  logic [2:0]        cfg_len0,
    input  logic [CNT_W-1:0]  cfg_cnt0,
    input  logic [2:0]        cfg_len1,
    input  logic [CNT_W-1:0]  cfg_cnt1,
    input  logic              cfg_delay,
    input  logic              cfg_fs_ignore,
    input  logic              cfg_clk_pol,
    input  logic              cfg_fs_pol,
    input  logic              bclk,
    input  logic              fsync,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              tx_sd,
    output logic              underrun
);

    logic              drive_ev;
    logic              fs_start;
    logic              buf_full;
    logic [WORD_W-1:0] buf_data;
    logic              pop;

    astx_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (tx_hold),
        .clk_pol  (cfg_clk_pol),
        .fs_pol   (cfg_fs_pol),
        .bclk     (bclk),
        .fsync    (fsync),
        .drive_ev (drive_ev),
        .fs_start (fs_start)
    );

    astx_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (tx_hold),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .pop      (pop),
        .full     (buf_full),
        .data     (buf_data)
    );

    astx_seq #(.CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold          (tx_hold),
        .drive_ev      (drive_ev),
        .fs_start      (fs_start),
        .cfg_dual      (cfg_dual),
        .cfg_len0      (cfg_len0),
        .cfg_cnt0      (cfg_cnt0),
        .cfg_len1      (cfg_len1),
        .cfg_cnt1      (cfg_cnt1),
        .cfg_delay     (cfg_delay),
        .cfg_fs_ignore (cfg_fs_ignore),
        .buf_full      (buf_full),
        .buf_data      (buf_data),
        .pop           (pop),
        .tx_sd         (tx_sd),
        .underrun      (underrun)
    );

endmodule

// File: tb/tb_audio_ser_tx.sv
`timescale 1ns/1ps
// Bench for audio_ser_tx: a queue-based behavioural model predicts the line,
// ready and underrun on every clock and is compared with the design.
module tb_audio_ser_tx;

    localparam int CNT_W = 7;

    logic             clk = 1'b0;
    logic             rst_n, tx_hold;
    logic             cfg_dual, cfg_delay, cfg_fs_ignore, cfg_clk_pol, cfg_fs_pol;
    logic [2:0]       cfg_len0, cfg_len1;
    logic [CNT_W-1:0] cfg_cnt0, cfg_cnt1;
    logic             bclk, fsync;
    logic [31:0]      in_data;
    logic             in_valid;
    logic             in_ready, tx_sd, underrun;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R7";
    bit    done = 0;

    // generator and feeder controls
    bit gen_run = 0;
    int fs_period = 32, fs_width = 1, fs_extra = -1, epoch = 0;
    bit feed_on = 0;

    // model state
    bit          m_bclk_q = 0, m_fs_prev = 1, m_full = 0, m_urun = 0;
    bit          m_act = 0, m_pend = 0, m_line = 0, m_acc = 0;
    logic [31:0] m_hd = '0, m_last = '0;
    int          lenq[$];
    bit          bitq[$];

    always #2.5 clk = ~clk;

    audio_ser_tx #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .tx_hold(tx_hold), .cfg_dual(cfg_dual),
        .cfg_len0(cfg_len0), .cfg_cnt0(cfg_cnt0), .cfg_len1(cfg_len1),
        .cfg_cnt1(cfg_cnt1), .cfg_delay(cfg_delay), .cfg_fs_ignore(cfg_fs_ignore),
        .cfg_clk_pol(cfg_clk_pol), .cfg_fs_pol(cfg_fs_pol), .bclk(bclk),
        .fsync(fsync), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .tx_sd(tx_sd), .underrun(underrun)
    );

    function automatic int wl(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    // list of word lengths for one whole frame (R2, R3)
    function void m_build();
        lenq.delete();
        bitq.delete();
        for (int i = 0; i <= int'(cfg_cnt0); i++) lenq.push_back(wl(cfg_len0));
        if (cfg_dual)
            for (int i = 0; i <= int'(cfg_cnt1); i++) lenq.push_back(wl(cfg_len1));
    endfunction

    // put the next frame bit on the model line, fetching a word if needed (R12)
    function void m_next();
        if (bitq.size() == 0) begin
            int          len;
            logic [31:0] w;
            len = lenq.pop_front();
            if (m_full) begin
                w = m_hd;
                m_full = 0;
            end else begin
                w = m_last;
                m_urun = 1;
            end
            m_last = w;
            for (int i = len - 1; i >= 0; i--) bitq.push_back(w[i]);
        end
        m_line = bitq.pop_front();
    endfunction

    // reference model, evaluated once per clock on the sampled inputs
    always @(posedge clk) begin
        bit ready_pre, ev, fsa, fst, fin, nxt, idle, ok;
        m_acc = 0;
        if (!rst_n) begin
            m_bclk_q = 0; m_fs_prev = 1; m_full = 0; m_urun = 0;
            m_act = 0; m_pend = 0; m_line = 0; m_last = '0;
            lenq.delete(); bitq.delete();
        end else begin
            ready_pre = !m_full && !tx_hold;
            ev = (bclk != m_bclk_q) && (bclk != cfg_clk_pol);
            m_bclk_q = bclk;
            if (tx_hold) begin
                m_fs_prev = 1; m_full = 0; m_urun = 0; m_act = 0;
                m_pend = 0; m_line = 0; m_last = '0;
                lenq.delete(); bitq.delete();
            end else begin
                if (ev) begin
                    fsa = fsync ^ cfg_fs_pol;
                    fst = fsa && !m_fs_prev;
                    m_fs_prev = fsa;
                    fin  = m_act && bitq.size() == 0 && lenq.size() == 0;
                    nxt  = m_act && bitq.size() == 1 && lenq.size() == 0;
                    idle = !m_act && !m_pend;
                    ok = fst && (idle || fin || (cfg_delay && nxt) || !cfg_fs_ignore);
                    if (ok && !cfg_delay) begin
                        m_build(); m_act = 1; m_pend = 0; m_next();
                    end else if (ok && nxt) begin
                        m_next(); m_act = 0; m_pend = 1;
                    end else if (ok) begin
                        m_line = 0; m_act = 0; m_pend = 1;
                        lenq.delete(); bitq.delete();
                    end else if (m_pend) begin
                        m_build(); m_pend = 0; m_act = 1; m_next();
                    end else if (m_act) begin
                        if (fin) begin m_act = 0; m_line = 0; end
                        else m_next();
                    end
                end
                if (in_valid && ready_pre) begin
                    m_full = 1; m_hd = in_data; m_acc = 1;
                end
            end
        end
    end

    task automatic chk(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // compare design and model shortly after every clock edge
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk(cur_req, tx_sd === m_line, "tx_sd", longint'(tx_sd), longint'(m_line));
            chk(cur_req, in_ready === (!m_full && !tx_hold), "in_ready R11",
                longint'(in_ready), longint'(!m_full && !tx_hold));
            chk(cur_req, underrun === m_urun, "underrun R12",
                longint'(underrun), longint'(m_urun));
        end
    end

    // bit clock and frame sync generator, 8 clk per bit
    initial begin : gen
        int bitpos;
        int seen;
        bit a;
        bitpos = 0; seen = 0; bclk = 0; fsync = 0;
        forever begin
            if (!gen_run) @(negedge clk);
            else begin
                if (seen != epoch) begin seen = epoch; bitpos = 0; end
                @(negedge clk);
                a = (bitpos < fs_width) || (bitpos == fs_extra);
                fsync = a ^ cfg_fs_pol;
                bclk = cfg_clk_pol;
                bitpos = (bitpos + 1) % fs_period;
                repeat (3) @(negedge clk);
                @(negedge clk);
                bclk = ~cfg_clk_pol;
                repeat (3) @(negedge clk);
            end
        end
    end

    // word feeder
    initial begin : feed
        int n;
        n = 1;
        in_valid = 0; in_data = '0;
        forever begin
            @(negedge clk);
            if (!feed_on) in_valid = 0;
            else if (!in_valid || m_acc) begin
                in_valid = 1;
                in_data = n * 32'h9E37_79B1 + 32'h0F0F_3C3C;
                n++;
            end
        end
    end

    task automatic setup(input bit dual, input logic [2:0] l0, input int c0,
                         input logic [2:0] l1, input int c1, input bit dly,
                         input bit fig, input bit cpol, input bit fpol,
                         input int per, input int wid, input int extra,
                         input string req);
        @(negedge clk);
        tx_hold = 1; feed_on = 0;
        cfg_dual = dual; cfg_len0 = l0; cfg_cnt0 = CNT_W'(c0);
        cfg_len1 = l1; cfg_cnt1 = CNT_W'(c1); cfg_delay = dly;
        cfg_fs_ignore = fig; cfg_clk_pol = cpol; cfg_fs_pol = fpol;
        fs_period = per; fs_width = wid; fs_extra = extra;
        epoch++;
        cur_req = req;
        repeat (4) @(negedge clk);
        feed_on = 1;
        tx_hold = 0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (120000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        rst_n = 0; tx_hold = 1;
        cfg_dual = 0; cfg_len0 = 3'd2; cfg_cnt0 = '0; cfg_len1 = 3'd2; cfg_cnt1 = '0;
        cfg_delay = 1; cfg_fs_ignore = 1; cfg_clk_pol = 1; cfg_fs_pol = 0;
        repeat (4) @(negedge clk);
        // reset state
        chk("R7", tx_sd === 1'b0, "reset tx_sd", longint'(tx_sd), 0);
        chk("R7", in_ready === 1'b0, "reset in_ready", longint'(in_ready), 0);
        chk("R12", underrun === 1'b0, "reset underrun", longint'(underrun), 0);
        rst_n = 1;
        gen_run = 1;
        run(4);
        chk("R11", in_ready === 1'b0, "in_ready under hold", longint'(in_ready), 0);

        // I2S-like: 2x16 bits, delay 1, active-low sync, back-to-back frames
        setup(0, 3'd2, 1, 3'd0, 0, 1, 1, 1, 1, 32, 16, -1, "R1 R2 R5 R9");
        run(3000);
        // dual phase 8 + 2x24, delay 0, rising drive edge, pulse sync
        setup(1, 3'd0, 0, 3'd4, 1, 0, 1, 0, 0, 60, 1, -1, "R3 R4 R8 R10");
        run(3000);
        // 3x12 bits back-to-back with delay 0
        setup(0, 3'd1, 2, 3'd0, 0, 0, 1, 1, 0, 36, 1, -1, "R2 R4 R1");
        run(3000);
        // dual 20 + 32 bits with delay 1, wide active-low sync
        setup(1, 3'd3, 0, 3'd5, 0, 1, 1, 0, 1, 60, 30, -1, "R1 R3 R5 R9");
        run(3000);
        // stray sync mid-frame ignored, code 6 = 32 bits
        setup(0, 3'd6, 0, 3'd0, 0, 0, 1, 1, 0, 40, 1, 10, "R6 R1");
        run(3000);
        // stray sync mid-frame restarts the frame
        setup(0, 3'd6, 0, 3'd0, 0, 0, 0, 1, 0, 40, 1, 10, "R6");
        run(3000);
        // restart with the one-bit delay
        setup(0, 3'd2, 1, 3'd0, 0, 1, 0, 0, 0, 40, 1, 20, "R6 R5");
        run(3000);

        // underrun: starve the holding register
        setup(1, 3'd0, 0, 3'd4, 1, 0, 1, 0, 0, 60, 1, -1, "R12");
        run(1000);
        feed_on = 0;
        run(1500);
        chk("R12", underrun === 1'b1, "underrun after starving", longint'(underrun), 1);
        feed_on = 1;
        run(600);
        chk("R12", underrun === 1'b1, "underrun sticky", longint'(underrun), 1);

        // hold in the middle of a frame
        setup(0, 3'd2, 1, 3'd0, 0, 1, 1, 1, 1, 32, 16, -1, "R7");
        run(1203);
        tx_hold = 1;
        @(negedge clk);
        chk("R7", tx_sd === 1'b0, "tx_sd under hold", longint'(tx_sd), 0);
        chk("R7", in_ready === 1'b0, "in_ready under hold", longint'(in_ready), 0);
        chk("R7", underrun === 1'b0, "underrun cleared", longint'(underrun), 0);
        run(2);
        tx_hold = 0;
        run(1500);

        done = 1;
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule